// File: doc/BRIEF.md
# Serial Heartbeat Classifier Inference Engine

This block classifies a single heartbeat segment of 100 signed samples with a small fully connected network of 100 inputs, 8 hidden neurons and 5 output neurons. All arithmetic runs on one reused multiply unit. A sequencer steps through the neurons one after another. For each hidden neuron it loads the bias, accumulates 100 products, clamps the sum to 16 bits and applies a rectifier. The output layer repeats the same steps over the eight hidden results, without the rectifier. The largest of the five outputs is then found by a sequential compare.

The surrounding system fills a feature buffer and a parameter buffer and then pulses the start input. The engine reads both buffers through request/address ports that answer combinationally in the same cycle. It raises a done pulse together with a class index from 1 to 5, where index n names output neuron n-1 in the parameter layout. All values are 16-bit two's complement with 8 fractional bits.

Top module: `beat_mlp_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, done_o, busy_o, feat_req_o and par_req_o are 0 and class_o is 0.
- R2: A start_i pulse sampled while idle sets busy_o, and in the cycle that follows both feat_req_o and par_req_o are high.
- R3: Parameter addresses are neuron-major. Hidden neuron k uses weight i at k*101+i and its bias at k*101+100. Output neuron j uses weight m at 808+j*9+m and its bias at 808+j*9+8. Each neuron's bias is fetched first, then its weights in rising input order. No address reaches 853 or above.
- R4: Each product of two 16-bit values is shifted right arithmetically by 8. The first product of a neuron is added to its bias, and each later product is added to the running sum in a wide accumulator. When stored, the sum is saturated to the range -32768..32767.
- R5: A stored hidden result with its sign bit set is replaced by 0. Non-negative results are kept unchanged.
- R6: Output neuron results are stored as signed values without the rectifier, so negative outputs still take part in the class choice.
- R7: The class starts as output 1 and is replaced by a later output only when that output is strictly greater. On a tie the lowest index wins, and class_o is always in 1..5 when done_o is high.
- R8: done_o is high for exactly one cycle. class_o changes only in that cycle and holds its value until the next done.
- R9: A start_i pulse while busy_o is high is ignored: it causes no restart, no change in latency and no extra done.
- R10: feat_req_o is high only in the request cycle and during hidden-layer accumulation. feat_addr_o then steps 0..99 in step with the hidden weight addresses.
- R11: done_o rises exactly 884 cycles after the clock edge that samples start_i. This equals 1 + 8*103 + 5*11 + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin inference (honoured only when idle) |
| feat_req_o | output | 1 | Feature buffer read request |
| feat_addr_o | output | 7 | Feature sample index |
| feat_data_i | input | 16 | Feature sample, Q7.8, valid in same cycle |
| par_req_o | output | 1 | Parameter buffer read request |
| par_addr_o | output | 10 | Parameter address |
| par_data_i | input | 16 | Weight or bias, Q7.8, valid in same cycle |
| class_o | output | 3 | Chosen class 1..5 |
| done_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | Inference in progress |

## Verification
The bench aims at the places where a plausible slip changes the chosen class. If the rectifier is missing, a negative hidden value passes through a negative weight and turns output 1 into the winner instead of output 5. If the rectifier is applied to the output layer, a set of all-negative outputs collapses to a tie at class 1 instead of class 2. If saturation is skipped or done by truncation, a positive or negative overflow wraps to a tiny value and moves the winner. A compare that uses greater-or-equal picks the later of two tied outputs. Separate runs probe the bias-first address order at layer boundaries, the exact latency, and a start pulse injected mid-run that must neither restart nor shift the result.

// File: rtl/beat_mlp_pkg.sv
package beat_mlp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_BIAS,
    ST_COMP,
    ST_STORE,
    ST_CHECK,
    ST_WAIT
  } mlp_state_e;
endpackage

// File: rtl/mlp_pu.sv
module mlp_pu #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic                 bias_sel_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] w_i,
  input  logic signed [DW-1:0] b_i,
  output logic        [DW-1:0] sat_o
);
  localparam int AW = 2 * DW;

  logic signed [AW-1:0] acc_q, prod, term, addend;
  logic [AW-DW:0] hi;

  assign prod   = a_i * w_i;
  assign term   = prod >>> FRAC;
  assign addend = bias_sel_i ? {{(AW-DW){b_i[DW-1]}}, b_i} : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= term + addend;
  end

  // clamp to DW bits when upper bits are not a pure sign extension
  assign hi = acc_q[AW-1:DW-1];
  always_comb begin
    if ((&hi) || !(|hi)) sat_o = acc_q[DW-1:0];
    else if (acc_q[AW-1]) sat_o = {1'b1, {(DW-1){1'b0}}};
    else                  sat_o = {1'b0, {(DW-1){1'b1}}};
  end
endmodule

// File: rtl/mlp_argmax.sv
module mlp_argmax #(
  parameter int N  = 5,
  parameter int DW = 16,
  parameter int IW = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [N-1:0][DW-1:0]   vals_i,
  output logic [IW-1:0]          cls_o,
  output logic                   done_o
);
  logic              run_q;
  logic [IW-1:0]     j_q, idx_q;
  logic signed [DW-1:0] best_q, cand;
  logic              gt;

  assign cand = vals_i[j_q];
  assign gt   = cand > best_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      j_q    <= '0;
      idx_q  <= '0;
      best_q <= '0;
      cls_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        run_q  <= 1'b1;
        j_q    <= IW'(1);
        idx_q  <= IW'(1);
        best_q <= vals_i[0];
      end else if (run_q) begin
        if (gt) begin
          best_q <= cand;
          idx_q  <= j_q + IW'(1);
        end
        j_q <= j_q + IW'(1);
        if (j_q == IW'(N - 1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
          cls_o  <= gt ? j_q + IW'(1) : idx_q;
        end
      end
    end
  end
endmodule

// File: rtl/beat_mlp_core.sv
module beat_mlp_core
  import beat_mlp_pkg::*;
#(
  parameter int N_IN  = 100,
  parameter int N_HID = 8,
  parameter int N_OUT = 5,
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  localparam int IC_W      = $clog2(N_IN),
  localparam int HID_SPAN  = N_IN + 1,
  localparam int OUT_SPAN  = N_HID + 1,
  localparam int OUT_BASE  = N_HID * HID_SPAN,
  localparam int PAR_DEPTH = OUT_BASE + N_OUT * OUT_SPAN,
  localparam int PA_W      = $clog2(PAR_DEPTH),
  localparam int CLS_W     = $clog2(N_OUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             feat_req_o,
  output logic [IC_W-1:0]  feat_addr_o,
  input  logic [DW-1:0]    feat_data_i,
  output logic             par_req_o,
  output logic [PA_W-1:0]  par_addr_o,
  input  logic [DW-1:0]    par_data_i,
  output logic [CLS_W-1:0] class_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int NMAX = (N_HID > N_OUT) ? N_HID : N_OUT;
  localparam int NW   = $clog2(NMAX);
  localparam int HI_W = $clog2(N_HID);

  mlp_state_e state_q;
  logic layer_q;
  logic [NW-1:0]   neu_q;
  logic [IC_W-1:0] in_q;
  logic [DW-1:0]   bias_q, sat, operand;
  logic [N_HID-1:0][DW-1:0] hid_q;
  logic [N_OUT-1:0][DW-1:0] out_q;
  logic last_in, last_neu, arg_go, arg_done;
  logic [PA_W-1:0] nbase, off;

  assign last_in  = layer_q ? (in_q == IC_W'(N_HID - 1)) : (in_q == IC_W'(N_IN - 1));
  assign last_neu = layer_q ? (neu_q == NW'(N_OUT - 1)) : (neu_q == NW'(N_HID - 1));
  assign operand  = layer_q ? hid_q[in_q[HI_W-1:0]] : feat_data_i;
  assign arg_go   = (state_q == ST_CHECK) && layer_q && last_neu;

  always_comb begin
    nbase = layer_q ? PA_W'(OUT_BASE) + PA_W'(neu_q) * PA_W'(OUT_SPAN)
                    : PA_W'(neu_q) * PA_W'(HID_SPAN);
    if (state_q == ST_BIAS) off = layer_q ? PA_W'(N_HID) : PA_W'(N_IN);
    else                    off = PA_W'(in_q);
    par_addr_o = nbase + off;
  end

  assign par_req_o   = (state_q == ST_REQ) || (state_q == ST_BIAS) || (state_q == ST_COMP);
  assign feat_req_o  = (state_q == ST_REQ) || ((state_q == ST_COMP) && !layer_q);
  assign feat_addr_o = layer_q ? '0 : in_q;
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      layer_q <= 1'b0;
      neu_q   <= '0;
      in_q    <= '0;
      bias_q  <= '0;
      hid_q   <= '0;
      out_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_REQ;
          layer_q <= 1'b0;
          neu_q   <= '0;
          in_q    <= '0;
        end
        ST_REQ: state_q <= ST_BIAS;
        ST_BIAS: begin
          bias_q  <= par_data_i;
          in_q    <= '0;
          state_q <= ST_COMP;
        end
        ST_COMP: begin
          if (last_in) state_q <= ST_STORE;
          else         in_q    <= in_q + IC_W'(1);
        end
        ST_STORE: begin
          if (layer_q) out_q[neu_q] <= sat;
          else         hid_q[neu_q[HI_W-1:0]] <= sat[DW-1] ? '0 : sat;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!last_neu) begin
            neu_q   <= neu_q + NW'(1);
            state_q <= ST_BIAS;
          end else if (!layer_q) begin
            layer_q <= 1'b1;
            neu_q   <= '0;
            state_q <= ST_BIAS;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (arg_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  mlp_pu #(.DW(DW), .FRAC(FRAC)) u_pu (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state_q == ST_BIAS),
    .en_i       (state_q == ST_COMP),
    .bias_sel_i (in_q == '0),
    .a_i        (operand),
    .w_i        (par_data_i),
    .b_i        (bias_q),
    .sat_o      (sat)
  );

  mlp_argmax #(.N(N_OUT), .DW(DW), .IW(CLS_W)) u_argmax (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (arg_go),
    .vals_i  (out_q),
    .cls_o   (class_o),
    .done_o  (arg_done)
  );

  assign done_o = arg_done;
endmodule

// File: rtl/mlp_chk.sv
module mlp_chk #(
  parameter int N_IN  = 100,
  parameter int N_HID = 8,
  parameter int N_OUT = 5,
  localparam int IC_W      = $clog2(N_IN),
  localparam int PAR_DEPTH = N_HID * (N_IN + 1) + N_OUT * (N_HID + 1),
  localparam int PA_W      = $clog2(PAR_DEPTH),
  localparam int CLS_W     = $clog2(N_OUT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             feat_req_o,
  input logic [IC_W-1:0]  feat_addr_o,
  input logic             par_req_o,
  input logic [PA_W-1:0]  par_addr_o,
  input logic [CLS_W-1:0] class_o,
  input logic             done_o,
  input logic             busy_o
);
  AST_START_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && par_req_o && feat_req_o)); // R2
  AST_PAR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_req_o |-> (int'(par_addr_o) < PAR_DEPTH)); // R3
  AST_CLASS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (class_o >= CLS_W'(1) && int'(class_o) <= N_OUT)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_CLASS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(class_o) |-> done_o); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R9
  AST_DONE_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R9
  AST_FEAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_req_o |-> (int'(feat_addr_o) < N_IN)); // R10
endmodule

bind beat_mlp_core mlp_chk #(.N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .feat_req_o  (feat_req_o),
  .feat_addr_o (feat_addr_o),
  .par_req_o   (par_req_o),
  .par_addr_o  (par_addr_o),
  .class_o     (class_o),
  .done_o      (done_o),
  .busy_o      (busy_o)
);

// File: tb/beat_mlp_core_bench.sv
`timescale 1ns/1ps
module beat_mlp_core_bench;
  localparam int N_IN = 100, N_HID = 8, N_OUT = 5;
  localparam int HSPAN = N_IN + 1, OSPAN = N_HID + 1;
  localparam int OBASE = N_HID * HSPAN;
  localparam int PDEP  = OBASE + N_OUT * OSPAN;
  localparam int LAT   = 1 + N_HID * (N_IN + 3) + N_OUT * (N_HID + 3) + (N_OUT - 1);
  // pattern id, expected class (0 = take the bench model)
  localparam int NVEC = 9;
  localparam int VEC [NVEC][2] = '{
    '{0, 1}, '{1, 2}, '{2, 2}, '{3, 5}, '{4, 1}, '{5, 3},
    '{11, 0}, '{12, 0}, '{13, 0}};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic feat_req, par_req, done, busy;
  logic [6:0] feat_addr;
  logic [9:0] par_addr;
  logic [15:0] feat_data, par_data;
  logic [2:0] cls;
  logic signed [15:0] feat_mem [N_IN];
  logic signed [15:0] par_mem [PDEP];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  assign feat_data = (int'(feat_addr) < N_IN) ? feat_mem[feat_addr] : '0;
  assign par_data  = (int'(par_addr) < PDEP) ? par_mem[par_addr] : '0;

  beat_mlp_core u_beat_mlp_core (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .feat_req_o(feat_req), .feat_addr_o(feat_addr), .feat_data_i(feat_data),
    .par_req_o(par_req), .par_addr_o(par_addr), .par_data_i(par_data),
    .class_o(cls), .done_o(done), .busy_o(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] hrand(input int s, input int a);
    int unsigned x;
    x = s * 32'h9E3779B9 ^ a * 32'h85EBCA6B;
    x ^= x >> 13; x *= 32'hC2B2AE35; x ^= x >> 16;
    return x[15:0];
  endfunction

  function automatic logic signed [15:0] sat16(input longint v);
    if (v > 32767) return 16'sh7FFF;
    if (v < -32768) return -16'sh8000;
    return 16'(v);
  endfunction

  function automatic int ref_class();
    logic signed [15:0] h [N_HID];
    logic signed [15:0] o [N_OUT];
    logic signed [15:0] best;
    int c;
    for (int k = 0; k < N_HID; k++) begin
      longint acc = longint'(par_mem[k*HSPAN + N_IN]);
      for (int i = 0; i < N_IN; i++)
        acc += (longint'(feat_mem[i]) * longint'(par_mem[k*HSPAN + i])) >>> 8;
      h[k] = sat16(acc);
      if (h[k] < 0) h[k] = '0;
    end
    for (int j = 0; j < N_OUT; j++) begin
      longint acc = longint'(par_mem[OBASE + j*OSPAN + N_HID]);
      for (int m = 0; m < N_HID; m++)
        acc += (longint'(h[m]) * longint'(par_mem[OBASE + j*OSPAN + m])) >>> 8;
      o[j] = sat16(acc);
    end
    best = o[0]; c = 1;
    for (int j = 1; j < N_OUT; j++) if (o[j] > best) begin best = o[j]; c = j + 1; end
    return c;
  endfunction

  task automatic load_pat(input int id);
    for (int i = 0; i < N_IN; i++) feat_mem[i] = '0;
    for (int a = 0; a < PDEP; a++) par_mem[a] = '0;
    case (id)
      0: ;
      1: begin
        par_mem[OBASE + 0*OSPAN + N_HID] = 16'sd1;  par_mem[OBASE + 1*OSPAN + N_HID] = 16'sd5;
        par_mem[OBASE + 2*OSPAN + N_HID] = 16'sd3;  par_mem[OBASE + 3*OSPAN + N_HID] = 16'sd5;
        par_mem[OBASE + 4*OSPAN + N_HID] = 16'sd2;
      end
      2: begin
        par_mem[OBASE + 0*OSPAN + N_HID] = -16'sd10; par_mem[OBASE + 1*OSPAN + N_HID] = -16'sd3;
        par_mem[OBASE + 2*OSPAN + N_HID] = -16'sd7;  par_mem[OBASE + 3*OSPAN + N_HID] = -16'sd3;
        par_mem[OBASE + 4*OSPAN + N_HID] = -16'sd20;
      end
      3: begin
        par_mem[N_IN] = -16'sd256;
        par_mem[OBASE] = -16'sd256;
        par_mem[OBASE + 4*OSPAN + N_HID] = 16'sd10;
      end
      4, 5: begin
        for (int i = 0; i < N_IN; i++) begin
          feat_mem[i] = 16'sh7FFF;
          par_mem[i]  = 16'sh7FFF;
        end
        if (id == 4) begin
          par_mem[OBASE] = 16'sd512;
          par_mem[OBASE + OSPAN] = 16'sd256;
        end else begin
          par_mem[OBASE] = -16'sd512;
          par_mem[OBASE + 2*OSPAN] = -16'sd256;
          par_mem[OBASE + 1*OSPAN + N_HID] = -16'sh8000;
          par_mem[OBASE + 3*OSPAN + N_HID] = -16'sh8000;
          par_mem[OBASE + 4*OSPAN + N_HID] = -16'sh8000;
        end
      end
      default: begin
        for (int i = 0; i < N_IN; i++) feat_mem[i] = $signed(hrand(id, i)) >>> 5;
        for (int a = 0; a < PDEP; a++) par_mem[a] = $signed(hrand(id + 77, a)) >>> 6;
      end
    endcase
  endtask

  function automatic string tag_of(input int id);
    case (id)
      0, 1: return "R7";
      2: return "R6";
      3: return "R5";
      4, 5: return "R4";
      default: return "R4/R5 model";
    endcase
  endfunction

  // one inference; probe checks addresses, poke injects start mid-run
  task automatic do_run(input bit probe, input bit poke, output int got);
    int lat = 0;
    got = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (probe) begin
      chk(busy === 1'b1, "R2 busy", int'(busy), 1);
      chk(feat_req === 1'b1 && par_req === 1'b1, "R2 requests", int'({feat_req, par_req}), 3);
    end
    while (lat < 5000) begin
      @(posedge clk); lat++; #1;
      if (poke) start = (lat == 300);
      if (probe) begin
        if (lat == 1)   chk(par_addr == 10'd100 && !feat_req, "R3 hidden bias first", int'(par_addr), 100);
        if (lat == 2)   chk(par_addr == 10'd0 && feat_addr == 7'd0 && feat_req, "R10 first feature", int'(feat_addr), 0);
        if (lat == 3)   chk(par_addr == 10'd1 && feat_addr == 7'd1, "R3 weight step", int'(par_addr), 1);
        if (lat == 101) chk(par_addr == 10'd99 && feat_addr == 7'd99, "R10 last feature", int'(feat_addr), 99);
        if (lat == 102) chk(!par_req && !feat_req, "R3 store idle", int'({feat_req, par_req}), 0);
        if (lat == 104) chk(par_addr == 10'd201, "R3 second hidden bias", int'(par_addr), 201);
        if (lat == 825) chk(par_addr == 10'd816 && !feat_req, "R3 output bias", int'(par_addr), 816);
        if (lat == 826) chk(par_addr == 10'd808 && !feat_req, "R10 output layer no feature", int'(par_addr), 808);
      end
      if (done) begin got = int'(cls); break; end
    end
    start = 1'b0;
    chk(lat == LAT, "R11 latency", lat, LAT);
    if (lat >= 5000) return;
    @(posedge clk); #1;
    chk(done === 1'b0, "R8 done one cycle", int'(done), 0);
    chk(int'(cls) == got, "R8 class held", int'(cls), got);
    repeat (3) @(posedge clk); #1;
    chk(busy === 1'b0 && done === 1'b0, "R9 no restart", int'(busy), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int got, exp;
    load_pat(0);
    repeat (3) @(posedge clk); #1;
    chk(!done && !busy && !feat_req && !par_req && cls == 3'd0, "R1 in reset",
        int'({done, busy, feat_req, par_req}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!done && !busy && !feat_req && !par_req && cls == 3'd0, "R1 after release",
        int'({done, busy, feat_req, par_req}), 0);

    for (int v = 0; v < NVEC; v++) begin
      load_pat(VEC[v][0]);
      exp = (VEC[v][1] != 0) ? VEC[v][1] : ref_class();
      do_run(1'b0, 1'b0, got);
      chk(got == exp, tag_of(VEC[v][0]), got, exp);
      chk(got >= 1 && got <= N_OUT, "R7 range", got, 1);
    end

    load_pat(21);
    exp = ref_class();
    do_run(1'b1, 1'b0, got);
    chk(got == exp, "R2/R3 probed run class", got, exp);

    load_pat(3);
    do_run(1'b0, 1'b1, got);
    chk(got == 5, "R9 start while busy", got, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule